// File: doc/BRIEF.md
# EDO DRAM Controller with Distributed Refresh

This block sits between a synchronous host and an asynchronous extended-data-out DRAM array with a 72-bit word made of eight byte lanes. The host presents one request at a time, either a read or a write, with a flat word address and one enable per byte lane. The controller splits the address into a row half and a column half on a shared multiplexed address bus. It sequences the row strobe, eight column strobes (one per lane), the write enable and the output enable. Reads come back to the host as a one-cycle valid pulse with the captured word.

Once a row has been opened, the controller leaves it open. A later request to the same row is served as an EDO page access: only the column strobes are pulsed and only a new column is presented. A request to a different row closes the page and waits out the precharge time first. A free-running interval timer raises a refresh request. That request wins over host traffic and closes any open page. The refresh is normally the CAS-before-RAS kind; a parameter switches periodic refresh to the RAS-only kind with an internal row counter. After reset the controller waits a set start-up time and performs eight CAS-before-RAS refreshes before it acknowledges the host. All timing intervals are parameters in clock cycles.

Top module: `edoMemCtrl`

## Requirements
- R1: While reset is asserted, memRasN=1, memCasN=8'hFF, memWeN=1, memOeN=1, memDqOe=0, reqAck=0 and rdValid=0.
- R2: After reset, reqAck stays low until INIT_CYCLES cycles have passed and eight CAS-before-RAS refreshes have completed on the pins.
- R3: A CAS-before-RAS refresh drives all eight column strobes low with the row strobe high for at least T_CSR cycles, then drives the row strobe low. Write enable stays high and the data bus is not driven.
- R4: A read opens the row, then drives all column strobes low with write enable high and output enable low. The word on memDqIn at the end of the T_CAS-cycle column-strobe window is returned on rdData with a single-cycle rdValid pulse.
- R5: In a write, write enable is low at least one cycle before the first column strobe falls, output enable stays high, and memDqOe is high only while write enable is low.
- R6: A write lowers column strobe i only when reqBe[i]=1. Lane i carries data bits [9i+8:9i]. Bytes of disabled lanes keep their previous contents.
- R7: A request to the row that is currently open is served without raising the row strobe. The column strobes are high for at least T_CP cycles between accesses.
- R8: A request to another row raises the row strobe, which then stays high at least T_RP cycles before it falls again.
- R9: A refresh is requested every REF_INTERVAL cycles. A pending refresh closes an open page and runs before any new host request.
- R10: The row is the upper ROW_BITS bits of reqAddr and the column is the lower 22-ROW_BITS bits. ROW_BITS is 11 (11/11 split) or 12 (12/10 split).
- R11: With RAS_ONLY_REF=1, a periodic refresh drives the row strobe low with all column strobes high and a counter row on memAddr. Consecutive refreshes use consecutive rows, starting at row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present; held until acknowledged |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_BITS | Flat word address |
| reqBe | input | 8 | Byte-lane enables for writes |
| reqWdata | input | 72 | Write data |
| reqAck | output | 1 | Request accepted this cycle |
| rdValid | output | 1 | One-cycle read data valid |
| rdData | output | 72 | Read data |
| memAddr | output | MUX_W | Multiplexed row/column address |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 8 | Per-lane column strobes, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDqOut | output | 72 | Data driven toward the array |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 72 | Data returned by the array |

## Verification
The pin-level properties assume the host holds reqValid and its fields stable until reqAck. They also assume every timing parameter is at least one. The stimulus issues one request at a time through a task that waits for the acknowledge before it releases the request, and it keeps the defaults for all strobe timings. The array model responds only while the row strobe, a column strobe and the output enable are low with write enable high. This keeps the returned data independent of bus states that the properties treat as idle.

// File: rtl/edoMemPkg.sv
package edoMemPkg;
  localparam int LANES = 8;

  typedef enum logic [1:0] {SEL_ROW, SEL_COL, SEL_REF} addrSel_e;

  // Strobes from sequencer to datapath; datapath registers them onto pins.
  typedef struct packed {
    logic     rasOn;
    logic     casAll;
    logic     casByBe;
    logic     weOn;
    logic     oeOn;
    addrSel_e addrSel;
    logic     dqDrive;
    logic     capture;
    logic     refRowInc;
    logic     latchReq;
  } memStrobe_t;
endpackage

// File: rtl/edoMemRefTimer.sv
module edoMemRefTimer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  output logic tick
);
  localparam int W = $clog2(INTERVAL + 1);
  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (!en) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (count == W'(INTERVAL - 1)) begin
      count <= '0;
      tick  <= 1'b1;
    end else begin
      count <= count + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/edoMemSeq.sv
module edoMemSeq import edoMemPkg::*; #(
  parameter int T_RCD        = 4,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 1,
  parameter int T_RP         = 4,
  parameter int T_CSR        = 1,
  parameter int T_RASR       = 6,
  parameter int INIT_CYCLES  = 20000,
  parameter int INIT_REFS    = 8,
  parameter bit RAS_ONLY_REF = 1'b0,
  parameter int CNT_W        = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       pageHit,
  input  logic       writeQ,
  input  logic       refTick,
  output logic       reqAck,
  output logic       ready,
  output memStrobe_t stb
);
  localparam int IL_W = $clog2(INIT_REFS + 1);

  typedef enum logic [3:0] {
    S_INIT, S_IDLE, S_ROW, S_PSET, S_COL, S_PAGE, S_PRE, S_CSR, S_CREF, S_RREF
  } seqState_e;

  seqState_e  state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [IL_W-1:0]  initLeft;
  logic refPend, takeRef, doneInitRef, cntZero;

  assign cntZero = (cnt == '0);
  assign ready   = (state != S_INIT) && (initLeft == '0);

  always_comb begin
    stb         = '0;
    stb.addrSel = SEL_COL;
    stateN      = state;
    cntN        = cntZero ? cnt : cnt - 1'b1;
    reqAck      = 1'b0;
    takeRef     = 1'b0;
    doneInitRef = 1'b0;
    unique case (state)
      S_INIT: if (cntZero) stateN = S_IDLE;
      S_IDLE: begin
        if (initLeft != '0 || refPend) begin
          takeRef = (initLeft == '0);
          if (initLeft == '0 && RAS_ONLY_REF) begin
            stateN = S_RREF;
            cntN   = CNT_W'(T_RASR - 1);
          end else begin
            stateN = S_CSR;
            cntN   = CNT_W'(T_CSR - 1);
          end
        end else if (reqValid) begin
          reqAck       = 1'b1;
          stb.latchReq = 1'b1;
          stateN       = S_ROW;
          cntN         = CNT_W'(T_RCD - 1);
        end
      end
      S_ROW: begin
        stb.rasOn   = 1'b1;
        stb.addrSel = SEL_ROW;
        stb.weOn    = writeQ;
        if (cntZero) begin
          stateN = S_COL;
          cntN   = CNT_W'(T_CAS - 1);
        end
      end
      S_PSET: begin
        stb.rasOn = 1'b1;
        stb.weOn  = writeQ;
        stateN    = S_COL;
        cntN      = CNT_W'(T_CAS - 1);
      end
      S_COL: begin
        stb.rasOn   = 1'b1;
        stb.casAll  = !writeQ;
        stb.casByBe = writeQ;
        stb.weOn    = writeQ;
        stb.oeOn    = !writeQ;
        stb.dqDrive = writeQ;
        stb.capture = !writeQ && cntZero;
        if (cntZero) begin
          stateN = S_PAGE;
          cntN   = CNT_W'(T_CP - 1);
        end
      end
      S_PAGE: begin
        stb.rasOn = 1'b1;
        if (cntZero) begin
          if (refPend) begin
            stateN = S_PRE;
            cntN   = CNT_W'(T_RP - 1);
          end else if (reqValid) begin
            if (pageHit) begin
              reqAck       = 1'b1;
              stb.latchReq = 1'b1;
              stateN       = S_PSET;
            end else begin
              stateN = S_PRE;
              cntN   = CNT_W'(T_RP - 1);
            end
          end
        end
      end
      S_PRE: if (cntZero) stateN = S_IDLE;
      S_CSR: begin
        stb.casAll = 1'b1;
        if (cntZero) begin
          stateN = S_CREF;
          cntN   = CNT_W'(T_RASR - 1);
        end
      end
      S_CREF: begin
        stb.rasOn  = 1'b1;
        stb.casAll = 1'b1;
        if (cntZero) begin
          stateN      = S_PRE;
          cntN        = CNT_W'(T_RP - 1);
          doneInitRef = (initLeft != '0);
        end
      end
      S_RREF: begin
        stb.rasOn   = 1'b1;
        stb.addrSel = SEL_REF;
        if (cntZero) begin
          stb.refRowInc = 1'b1;
          stateN        = S_PRE;
          cntN          = CNT_W'(T_RP - 1);
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_INIT;
      cnt      <= CNT_W'(INIT_CYCLES - 1);
      initLeft <= IL_W'(INIT_REFS);
      refPend  <= 1'b0;
    end else begin
      state   <= stateN;
      cnt     <= cntN;
      refPend <= (refPend && !takeRef) || refTick;
      if (doneInitRef) initLeft <= initLeft - 1'b1;
    end
  end
endmodule

// File: rtl/edoMemPath.sv
module edoMemPath import edoMemPkg::*; #(
  parameter int ADDR_BITS = 22,
  parameter int ROW_BITS  = 11,
  parameter int LANE_W    = 9,
  parameter int COL_BITS  = ADDR_BITS - ROW_BITS,
  parameter int MUX_W     = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS,
  parameter int DATA_W    = LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  memStrobe_t           stb,
  input  logic [ADDR_BITS-1:0] reqAddr,
  input  logic                 reqWrite,
  input  logic [LANES-1:0]     reqBe,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    memDqIn,
  output logic                 pageHit,
  output logic                 writeQ,
  output logic [MUX_W-1:0]     memAddr,
  output logic                 memRasN,
  output logic [LANES-1:0]     memCasN,
  output logic                 memWeN,
  output logic                 memOeN,
  output logic [DATA_W-1:0]    memDqOut,
  output logic                 memDqOe,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    rdData
);
  logic [ROW_BITS-1:0] rowQ, refRow;
  logic [COL_BITS-1:0] colQ;
  logic [LANES-1:0]    beQ;
  logic [DATA_W-1:0]   wdataQ;
  logic [MUX_W-1:0]    addrNext;
  logic [LANES-1:0]    casNext;
  logic                capD;

  assign pageHit  = (reqAddr[ADDR_BITS-1 -: ROW_BITS] == rowQ);
  assign memDqOut = wdataQ;

  always_comb begin
    unique case (stb.addrSel)
      SEL_ROW: addrNext = MUX_W'(rowQ);
      SEL_REF: addrNext = MUX_W'(refRow);
      default: addrNext = MUX_W'(colQ);
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign casNext[i] = !(stb.casAll || (stb.casByBe && beQ[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ   <= '0;
      colQ   <= '0;
      beQ    <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
      refRow <= '0;
    end else begin
      if (stb.latchReq) begin
        rowQ   <= reqAddr[ADDR_BITS-1 -: ROW_BITS];
        colQ   <= reqAddr[COL_BITS-1:0];
        beQ    <= reqBe;
        wdataQ <= reqWdata;
        writeQ <= reqWrite;
      end
      if (stb.refRowInc) refRow <= refRow + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memRasN <= 1'b1;
      memCasN <= '1;
      memWeN  <= 1'b1;
      memOeN  <= 1'b1;
      memDqOe <= 1'b0;
      capD    <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      memAddr <= addrNext;
      memRasN <= !stb.rasOn;
      memCasN <= casNext;
      memWeN  <= !stb.weOn;
      memOeN  <= !stb.oeOn;
      memDqOe <= stb.dqDrive;
      capD    <= stb.capture;
      rdValid <= capD;
      if (capD) rdData <= memDqIn;
    end
  end
endmodule

// File: rtl/edoMemCtrl.sv
module edoMemCtrl import edoMemPkg::*; #(
  parameter int ADDR_BITS    = 22,
  parameter int ROW_BITS     = 11,
  parameter int LANE_W       = 9,
  parameter int T_RCD        = 4,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 1,
  parameter int T_RP         = 4,
  parameter int T_CSR        = 1,
  parameter int T_RASR       = 6,
  parameter int REF_INTERVAL = 1560,
  parameter int INIT_CYCLES  = 20000,
  parameter int INIT_REFS    = 8,
  parameter bit RAS_ONLY_REF = 1'b0,
  parameter int COL_BITS     = ADDR_BITS - ROW_BITS,
  parameter int MUX_W        = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS,
  parameter int DATA_W       = LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_BITS-1:0] reqAddr,
  input  logic [LANES-1:0]     reqBe,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 reqAck,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    rdData,
  output logic [MUX_W-1:0]     memAddr,
  output logic                 memRasN,
  output logic [LANES-1:0]     memCasN,
  output logic                 memWeN,
  output logic                 memOeN,
  output logic [DATA_W-1:0]    memDqOut,
  output logic                 memDqOe,
  input  logic [DATA_W-1:0]    memDqIn
);
  localparam int CNT_W = $clog2(INIT_CYCLES + T_RCD + T_CAS + T_CP + T_RP + T_CSR + T_RASR + 2);

  memStrobe_t stb;
  logic pageHit, writeQ, refTick, ready;

  edoMemRefTimer #(.INTERVAL(REF_INTERVAL)) uTimer (
    .clk(clk), .rstN(rstN), .en(ready), .tick(refTick)
  );

  edoMemSeq #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_CSR(T_CSR),
    .T_RASR(T_RASR), .INIT_CYCLES(INIT_CYCLES), .INIT_REFS(INIT_REFS),
    .RAS_ONLY_REF(RAS_ONLY_REF), .CNT_W(CNT_W)
  ) uSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pageHit(pageHit),
    .writeQ(writeQ), .refTick(refTick), .reqAck(reqAck), .ready(ready), .stb(stb)
  );

  edoMemPath #(
    .ADDR_BITS(ADDR_BITS), .ROW_BITS(ROW_BITS), .LANE_W(LANE_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqBe(reqBe), .reqWdata(reqWdata), .memDqIn(memDqIn), .pageHit(pageHit),
    .writeQ(writeQ), .memAddr(memAddr), .memRasN(memRasN), .memCasN(memCasN),
    .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/edoMemCheck.sv
module edoMemCheck import edoMemPkg::*; #(
  parameter int T_RP = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqAck,
  input logic             memRasN,
  input logic [LANES-1:0] memCasN,
  input logic             memWeN,
  input logic             memOeN,
  input logic             memDqOe,
  input logic             rdValid
);
  localparam int HW = $clog2(T_RP + 2);
  logic [HW-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highCnt <= HW'(T_RP);
    else if (!memRasN) highCnt <= '0;
    else if (highCnt < HW'(T_RP)) highCnt <= highCnt + 1'b1;
  end

  // R3: refresh setup keeps WE high and the bus undriven
  a_r3_cbr_setup: assert property (@(posedge clk) disable iff (!rstN)
    (memRasN && memCasN != '1) |-> (memCasN == '0 && memWeN && !memDqOe));

  // R3: row strobe falling under low column strobes has WE high
  a_r3_cbr_we_high: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memRasN) && memCasN == '0) |-> memWeN);

  // R5: early write, WE leads the column strobe
  a_r5_early_write: assert property (@(posedge clk) disable iff (!rstN)
    (!memRasN && $past(memCasN) == '1 && memCasN != '1 && !memWeN) |-> !$past(memWeN));

  // R5: bus driven only in writes, never against the array outputs
  a_r5_drive_only_write: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memWeN && memOeN));

  // R4: read valid is a single-cycle pulse
  a_r4_rd_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R8: precharge before each new row strobe
  a_r8_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memRasN) |-> (highCnt >= HW'(T_RP)));

  // R2: acknowledge only answers a request
  a_r2_ack_has_req: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> reqValid);
endmodule

bind edoMemCtrl edoMemCheck #(.T_RP(T_RP)) uCheck (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAck(reqAck),
  .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN), .memOeN(memOeN),
  .memDqOe(memDqOe), .rdValid(rdValid)
);

// File: tb/tb_edoMemCtrl.sv
module tb_edoMemCtrl;
  localparam int INIT = 40;
  localparam int TRP  = 4;
  localparam int TCSR = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [7:0]  reqBe = '0;
  logic [71:0] reqWdata = '0;
  logic        reqAck, rdValid, memRasN, memWeN, memOeN, memDqOe;
  logic [71:0] rdData, memDqOut;
  logic [71:0] memDqIn = '0;
  logic [10:0] memAddr;
  logic [7:0]  memCasN;

  edoMemCtrl #(.INIT_CYCLES(INIT), .REF_INTERVAL(1000)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata), .reqAck(reqAck),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memRasN(memRasN),
    .memCasN(memCasN), .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // second instance: 12/10 split with RAS-only periodic refresh
  logic        r2Valid = 1'b0;
  logic [21:0] r2Addr = '0;
  logic        r2Ack, r2RdValid, r2RasN, r2WeN, r2OeN, r2DqOe;
  logic [71:0] r2RdData, r2DqOut;
  logic [11:0] r2MemAddr;
  logic [7:0]  r2CasN;

  edoMemCtrl #(.ROW_BITS(12), .RAS_ONLY_REF(1'b1), .INIT_CYCLES(INIT), .REF_INTERVAL(300)) dutRo (
    .clk(clk), .rstN(rstN), .reqValid(r2Valid), .reqWrite(1'b1),
    .reqAddr(r2Addr), .reqBe(8'hFF), .reqWdata(72'h0), .reqAck(r2Ack),
    .rdValid(r2RdValid), .rdData(r2RdData), .memAddr(r2MemAddr), .memRasN(r2RasN),
    .memCasN(r2CasN), .memWeN(r2WeN), .memOeN(r2OeN), .memDqOut(r2DqOut),
    .memDqOe(r2DqOe), .memDqIn(72'h0)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rstN) cyc++;

  // ---------------- array model for dut ----------------
  logic [71:0] dram [int];
  logic [71:0] refMem [int];
  logic [10:0] rowQ = '0, lastRow = '0, lastCol = '0;
  logic        prevRas = 1'b1, prevWe = 1'b1;
  logic [7:0]  prevCas = 8'hFF;
  int cbrCnt = 0, actCnt = 0, rasHigh = 0, lastHigh = 0, casLowPre = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevRas && !memRasN) begin
        lastHigh = rasHigh;
        if (memCasN == 8'h00) begin
          cbrCnt++;
          check(memWeN && !memDqOe && casLowPre >= TCSR, "R3 cbr sequence",
                {casLowPre[7:0], memWeN, memDqOe}, {8'(TCSR), 2'b10});
        end else if (memCasN == 8'hFF) begin
          actCnt++;
          rowQ = memAddr;
          lastRow = memAddr;
        end
      end
      if (!memRasN && prevCas == 8'hFF && memCasN != 8'hFF) begin
        lastCol = memAddr;
        if (!memWeN)
          check(!prevWe && memOeN && memDqOe, "R5 early write", {prevWe, memOeN, memDqOe}, 3'b011);
      end
      if (memDqOe && memWeN) check(1'b0, "R5 bus driven outside write", 1, 0);
      if (!memRasN && !memWeN) begin
        int key;
        logic [71:0] cur;
        key = int'({rowQ, memAddr});
        cur = dram.exists(key) ? dram[key] : 72'h0;
        for (int i = 0; i < 8; i++)
          if (prevCas[i] && !memCasN[i]) cur[i*9 +: 9] = memDqOut[i*9 +: 9];
        dram[key] = cur;
      end
      if (!memRasN && memCasN != 8'hFF && memWeN && !memOeN) begin
        int key;
        key = int'({rowQ, memAddr});
        memDqIn = dram.exists(key) ? dram[key] : 72'h0;
      end else memDqIn = 72'h0;
      casLowPre = (memRasN && memCasN == 8'h00) ? casLowPre + 1 : 0;
      rasHigh   = memRasN ? rasHigh + 1 : 0;
      prevRas = memRasN;
      prevCas = memCasN;
      prevWe  = memWeN;
    end
  end

  // ---------------- watcher for dutRo ----------------
  logic [11:0] nextRef2 = '0, accRow2 = '0;
  logic [9:0]  accCol2 = '0;
  logic        prevRas2 = 1'b1;
  logic [7:0]  prevCas2 = 8'hFF;
  int rorCnt2 = 0, accCnt2 = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevRas2 && !r2RasN && r2CasN == 8'hFF) begin
        if (r2MemAddr == nextRef2) begin
          rorCnt2++;
          nextRef2 = nextRef2 + 1'b1;
        end else begin
          accCnt2++;
          accRow2 = r2MemAddr;
        end
      end
      if (!r2RasN && prevCas2 == 8'hFF && r2CasN != 8'hFF) accCol2 = r2MemAddr[9:0];
      prevRas2 = r2RasN;
      prevCas2 = r2CasN;
    end
  end

  // ---------------- scoreboard ----------------
  logic [71:0] expQ [$];

  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check(1'b0, "R4 unexpected read data", rdData, 72'h0);
      else begin
        logic [71:0] e;
        e = expQ.pop_front();
        check(rdData === e, "R4/R6/R7 read data", rdData, e);
      end
    end
  end

  task automatic issue(input logic w, input logic [21:0] a, input logic [7:0] be, input logic [71:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqBe = be; reqWdata = d;
    #1;
    while (!reqAck) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic doWrite(input logic [21:0] a, input logic [7:0] be, input logic [71:0] d);
    logic [71:0] cur;
    cur = refMem.exists(int'(a)) ? refMem[int'(a)] : 72'h0;
    for (int i = 0; i < 8; i++) if (be[i]) cur[i*9 +: 9] = d[i*9 +: 9];
    refMem[int'(a)] = cur;
    issue(1'b1, a, be, d);
  endtask

  task automatic doRead(input logic [21:0] a);
    expQ.push_back(refMem.exists(int'(a)) ? refMem[int'(a)] : 72'h0);
    issue(1'b0, a, 8'h00, 72'h0);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  localparam logic [21:0] A0 = 22'h12345;
  localparam logic [21:0] A1 = 22'h3F0010;
  localparam logic [21:0] A2 = 22'h0A0020;

  initial begin
    int c, a;
    repeat (3) @(negedge clk);
    // R1: reset state of all outputs
    check({memRasN, memCasN, memWeN, memOeN, memDqOe, reqAck, rdValid} == 15'b1_11111111_11_000,
          "R1 reset outputs", {memRasN, memCasN, memWeN, memOeN, memDqOe, reqAck, rdValid},
          15'b1_11111111_11_000);
    rstN = 1'b1;

    // R2: request waits for start-up time and eight refreshes
    doWrite(A0, 8'hFF, 72'h12_3456_789A_BCDE_F011);
    check(cbrCnt == 8 && cyc >= INIT, "R2 init refreshes before ack", cbrCnt, 8);
    repeat (10) @(negedge clk);
    // R10: 11/11 split on the address pins
    check(lastRow == A0[21:11] && lastCol == A0[10:0], "R10 row/column split 11/11",
          {lastRow, lastCol}, {A0[21:11], A0[10:0]});

    // R4: read back
    doRead(A0);
    // R6: partial write merges lanes 0..3
    doWrite(A0, 8'h0F, 72'hFF_FFFF_FFFF_FFFF_FFFF);
    doRead(A0);
    doWrite(A0, 8'hA0, 72'h55_AAAA_5555_AAAA_5555);
    doRead(A0);
    drain();

    // R7: same-row accesses right after a refresh stay in the open page
    c = cbrCnt;
    while (cbrCnt == c) @(negedge clk);
    a = actCnt;
    doWrite(A1, 8'hFF, 72'h01_0203_0405_0607_0809);
    doWrite(A1 + 22'd1, 8'hFF, 72'h10_2030_4050_6070_8090);
    doRead(A1);
    doRead(A1 + 22'd1);
    drain();
    check(actCnt == a + 1, "R7 page hits keep row open", actCnt, a + 1);

    // R8: row miss closes and precharges
    a = actCnt;
    doWrite(A2, 8'hFF, 72'hC0_FFEE_0000_1111_2222);
    doRead(A2);
    drain();
    check(actCnt == a + 1, "R8 row miss reopens once", actCnt, a + 1);
    check(lastHigh >= TRP, "R8 precharge time", lastHigh, TRP);
    doRead(A1);
    drain();

    // R9: refreshes continue while a page is left open
    c = cbrCnt;
    repeat (3500) @(negedge clk);
    check(cbrCnt - c >= 3 && cbrCnt - c <= 4, "R9 refresh rate with page open", cbrCnt - c, 3);
    doRead(A0);
    drain();

    // R11: RAS-only refresh on the second instance, rows in sequence
    check(rorCnt2 >= 3, "R11 RAS-only refresh count", rorCnt2, 3);
    check(accCnt2 == 0, "R11 refresh rows consecutive", accCnt2, 0);

    // R10: 12/10 split on the second instance
    @(negedge clk);
    r2Addr = 22'h2ABCD;
    r2Valid = 1'b1;
    #1;
    while (!r2Ack) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 r2Valid = 1'b0;
    repeat (12) @(negedge clk);
    check(accRow2 == 12'hAA && accCol2 == 10'h3CD, "R10 row/column split 12/10",
          {accRow2, accCol2}, {12'hAA, 10'h3CD});
    check(accCnt2 == 1, "R11 only host access leaves refresh sequence", accCnt2, 1);

    finishRun();
  end
endmodule